// File: doc/BRIEF.md
# Clock Distributor Configuration Slave (I2C)

This block is the serial configuration port of a zero-delay clock distribution chip. It watches SCL and SDA with the system clock, drives SDA low through an open-drain enable, and keeps twelve byte-wide control registers. The decoded control fields reach the analog side as parallel ports: per-pair output enables, group skew codes, skew bypass bits, the feedback skew code, the input delay code and the drive strength codes.

Transfers use a block exchange and have no register address. In a write, the two bytes after the address (a command byte and a count byte) are acknowledged and thrown away. The data bytes that follow land in register 0, 1, 2 and upwards. In a read, the slave sends a fixed count byte first and then the registers from index 0 upwards. Every START and every STOP sends the sequence back to register 0.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The slave acknowledges only the address {1101010 | addrSel}, that is 1101010 when addrSel=0 and 1101011 when addrSel=1, with the R/W bit last (1 = read). Any other address gets no acknowledge, and the bytes that follow it change nothing.
- R2: In a write, the slave acknowledges every byte. The first two bytes after the address are discarded. Byte k after them (k from 0) is written to register k.
- R3: In a read, the first byte sent after the address acknowledge is 0x09. Registers 0, 1, 2 and upwards follow, one per byte, each shifted out MSB first.
- R4: Only these bits are writable: reg5 bits 5:0, reg6 bits 5:3, reg7 bits 7:3, reg8 bits 6:0, reg9 and reg10 bits 5:3, reg11 bits 2:0. Every other bit, including all of registers 0 to 4, ignores writes and reads back its reset value.
- R5: Reset values are 0xFF for registers 0 to 4, then reg5=0x3F, reg6=0x18, reg7=0xD8, reg8=0xB0, reg9=0xD8, reg10=0xD8, reg11=0xFB. The ports decode the registers as follows: pairEnable=reg5[5:0], skewGrpA=reg6[5:3], skewGrpB=reg7[5:3], grpSkewBypass=reg7[7], fbSkewBypass=reg7[6], fbSkew=reg8[6:4], inDelay=reg8[3:0], driveGrpA=reg9[5:3], driveGrpB=reg10[5:3], driveFb=reg11[2:0].
- R6: Write bytes aimed past register 11 are acknowledged and discarded. Read bytes past register 11 are 0xFF.
- R7: When the master does not acknowledge a read byte, the transfer ends. The slave leaves SDA released until the next START.
- R8: A STOP or a START, including a repeated START, returns the sequence to the header bytes and register 0.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| addrSel | input | 1 | Selects the address LSB |
| scl | input | 1 | Serial clock from the bus |
| sdaIn | input | 1 | Level of the SDA line |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| pairEnable | output | 6 | Enable for each differential output pair |
| skewGrpA | output | 3 | Skew code for output group A |
| skewGrpB | output | 3 | Skew code for output group B |
| grpSkewBypass | output | 1 | 1 disables the group skew channels |
| fbSkewBypass | output | 1 | 1 disables the feedback skew channel |
| fbSkew | output | 3 | Feedback output skew code |
| inDelay | output | 4 | Input delay code |
| driveGrpA | output | 3 | Drive strength code, group A |
| driveGrpB | output | 3 | Drive strength code, group B |
| driveFb | output | 3 | Drive strength code, feedback output |

## Verification
The assertions watch several rules on every cycle. The SDA drive may change only while SCL is low. The pointer is back at register 0 two cycles after a START. SDA is released in the cycle after a STOP. The decoded outputs move only after a write commit, and the pointer never runs past its saturation value. Other behaviour shows only in the bench's transfers: address matching for both select values, the discarded header bytes, the count byte at the head of a read, the read-back of reserved bits, the 0xFF bytes past the end, the restart at register 0 after a repeated START, and the released bus after a NACK. The bench's cycle-by-cycle model of the decoded outputs catches any field written to the wrong register or bit.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

  localparam int BYTE_W = 8;

  // control-to-datapath strobes, one cycle wide
  typedef struct packed {
    logic ptrClear;
    logic commit;
    logic advance;
  } cfgStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RXBYTE,
    ST_RXACK,
    ST_TXBYTE,
    ST_TXACK
  } busState_t;

  function automatic logic [BYTE_W-1:0] regResetVal(input int idx);
    case (idx)
      5:       return 8'h3F;
      6:       return 8'h18;
      7:       return 8'hD8;
      8:       return 8'hB0;
      9, 10:   return 8'hD8;
      11:      return 8'hFB;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] regWriteMask(input int idx);
    case (idx)
      5:       return 8'h3F;
      6:       return 8'h38;
      7:       return 8'hF8;
      8:       return 8'h7F;
      9, 10:   return 8'h38;
      11:      return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/clkcfg_i2c_ctrl.sv
module clkcfg_i2c_ctrl
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b110101,
  parameter logic [BYTE_W-1:0] COUNT_BYTE = 8'h09,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrSel,
  input  logic              scl,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rdByte,
  output cfgStrobe_t        stb,
  output logic [BYTE_W-1:0] wrByte,
  output logic              sdaOe,
  output logic              startSeen,
  output logic              stopSeen
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclQ, sdaQ;
  logic sclRise, sclFall;

  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic byteDone;
  logic readMode;
  logic [1:0] hdrLeft;
  logic addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclQ    <= 1'b1;
      sdaQ    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], scl};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclQ    <= sclNow;
      sdaQ    <= sdaNow;
    end
  end

  assign sclNow    = sclSync[SYNC_STAGES-1];
  assign sdaNow    = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclQ;
  assign sclFall   = ~sclNow & sclQ;
  assign startSeen = sclNow & sclQ & sdaQ & ~sdaNow;
  assign stopSeen  = sclNow & sclQ & ~sdaQ & sdaNow;
  assign addrHit   = (rxShift[BYTE_W-1:1] == {ADDR_HI, addrSel});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '1;
      byteDone <= 1'b0;
      readMode <= 1'b0;
      hdrLeft  <= '0;
      stb      <= '0;
      wrByte   <= '0;
    end else begin
      stb <= '0;
      if (startSeen) begin
        state        <= ST_ADDR;
        bitCnt       <= '0;
        byteDone     <= 1'b0;
        stb.ptrClear <= 1'b1;
      end else if (stopSeen) begin
        state        <= ST_IDLE;
        stb.ptrClear <= 1'b1;
      end else begin
        case (state)
          ST_ADDR, ST_RXBYTE: begin
            if (sclRise) begin
              rxShift <= {rxShift[BYTE_W-2:0], sdaNow};
              bitCnt  <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              bitCnt   <= '0;
              if (state == ST_ADDR) begin
                if (addrHit) begin
                  state    <= ST_RXACK;
                  readMode <= rxShift[0];
                  hdrLeft  <= rxShift[0] ? 2'd1 : 2'd2;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state <= ST_RXACK;
                if (hdrLeft != 2'd0) begin
                  hdrLeft <= hdrLeft - 2'd1;
                end else begin
                  stb.commit <= 1'b1;
                  wrByte     <= rxShift;
                end
              end
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readMode) begin
                state   <= ST_TXBYTE;
                txShift <= COUNT_BYTE;
              end else begin
                state <= ST_RXBYTE;
              end
            end
          end
          ST_TXBYTE: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                state <= ST_TXACK;
              end else begin
                txShift <= {txShift[BYTE_W-2:0], 1'b1};
                bitCnt  <= bitCnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) begin
              if (sdaNow) begin
                state <= ST_IDLE;
              end else if (hdrLeft != 2'd0) begin
                hdrLeft <= 2'd0;
              end else begin
                stb.advance <= 1'b1;
              end
            end else if (sclFall) begin
              state   <= ST_TXBYTE;
              txShift <= rdByte;
              bitCnt  <= '0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sdaOe = (state == ST_RXACK) | ((state == ST_TXBYTE) & ~txShift[BYTE_W-1]);

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int PTR_W = $clog2(NUM_REGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        stb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic [BYTE_W-1:0] rdByte,
  output logic [PTR_W-1:0]  regPtr,
  output logic [5:0]        pairEnable,
  output logic [2:0]        skewGrpA,
  output logic [2:0]        skewGrpB,
  output logic              grpSkewBypass,
  output logic              fbSkewBypass,
  output logic [2:0]        fbSkew,
  output logic [3:0]        inDelay,
  output logic [2:0]        driveGrpA,
  output logic [2:0]        driveGrpB,
  output logic [2:0]        driveFb
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPtr <= '0;
    end else if (stb.ptrClear) begin
      regPtr <= '0;
    end else if ((stb.commit || stb.advance) && regPtr != PTR_END) begin
      regPtr <= regPtr + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] RST_V = regResetVal(g);
    localparam logic [BYTE_W-1:0] WR_M  = regWriteMask(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= RST_V;
      end else if (stb.commit && regPtr == PTR_W'(g)) begin
        regQ[g] <= (regQ[g] & ~WR_M) | (wrByte & WR_M);
      end
    end
  end

  always_comb begin
    rdByte = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (regPtr == PTR_W'(i)) rdByte = regQ[i];
    end
  end

  assign pairEnable    = regQ[5][5:0];
  assign skewGrpA      = regQ[6][5:3];
  assign skewGrpB      = regQ[7][5:3];
  assign grpSkewBypass = regQ[7][7];
  assign fbSkewBypass  = regQ[7][6];
  assign fbSkew        = regQ[8][6:4];
  assign inDelay       = regQ[8][3:0];
  assign driveGrpA     = regQ[9][5:3];
  assign driveGrpB     = regQ[10][5:3];
  assign driveFb       = regQ[11][2:0];

endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target
  import clkcfg_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter logic [5:0] ADDR_HI = 6'b110101,
  parameter logic [7:0] COUNT_BYTE = 8'h09
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrSel,
  input  logic       scl,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [5:0] pairEnable,
  output logic [2:0] skewGrpA,
  output logic [2:0] skewGrpB,
  output logic       grpSkewBypass,
  output logic       fbSkewBypass,
  output logic [2:0] fbSkew,
  output logic [3:0] inDelay,
  output logic [2:0] driveGrpA,
  output logic [2:0] driveGrpB,
  output logic [2:0] driveFb
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);

  cfgStrobe_t        ctlStb;
  logic [BYTE_W-1:0] wrByte, rdByte;
  logic [PTR_W-1:0]  regPtr;
  logic              startSeen, stopSeen;

  clkcfg_i2c_ctrl #(
    .ADDR_W(7), .ADDR_HI(ADDR_HI), .COUNT_BYTE(COUNT_BYTE), .SYNC_STAGES(2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .scl(scl), .sdaIn(sdaIn),
    .rdByte(rdByte), .stb(ctlStb), .wrByte(wrByte), .sdaOe(sdaOe),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  clkcfg_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) i_bank (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .wrByte(wrByte), .rdByte(rdByte),
    .regPtr(regPtr), .pairEnable(pairEnable), .skewGrpA(skewGrpA),
    .skewGrpB(skewGrpB), .grpSkewBypass(grpSkewBypass),
    .fbSkewBypass(fbSkewBypass), .fbSkew(fbSkew), .inDelay(inDelay),
    .driveGrpA(driveGrpA), .driveGrpB(driveGrpB), .driveFb(driveFb)
  );

endmodule

// File: rtl/clkcfg_checker.sv
module clkcfg_checker #(
  parameter int NUM_REGS = 12,
  parameter int PTR_W = $clog2(NUM_REGS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             scl,
  input logic             sdaOe,
  input logic [5:0]       pairEnable,
  input logic             commitStb,
  input logic             startSeen,
  input logic             stopSeen,
  input logic [PTR_W-1:0] regPtr
);

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !scl);

  assert_restart_ptr_R8: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> ##1 (regPtr == '0));

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaOe);

  assert_out_after_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pairEnable) |-> $past(commitStb));

  assert_ptr_bounded_R6: assert property (@(posedge clk) disable iff (!rstN)
    regPtr <= PTR_W'(NUM_REGS));

endmodule

bind clkcfg_i2c_target clkcfg_checker #(.NUM_REGS(NUM_REGS)) i_checker (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaOe(sdaOe), .pairEnable(pairEnable),
  .commitStb(ctlStb.commit), .startSeen(startSeen), .stopSeen(stopSeen),
  .regPtr(regPtr)
);

// File: tb/test_clkcfg_i2c_target.sv
module test_clkcfg_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 20;
  localparam int QTR = 4;
  localparam int NREG = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrSel = 1'b0;
  logic mLow = 1'b0;
  logic sclLow = 1'b0;
  logic sdaOe;
  logic sclLine, sdaLine;
  logic [5:0] pairEnable;
  logic [2:0] skewGrpA, skewGrpB, fbSkew, driveGrpA, driveGrpB, driveFb;
  logic grpSkewBypass, fbSkewBypass;
  logic [3:0] inDelay;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclLine = ~sclLow;
  assign sdaLine = ~(mLow | sdaOe);

  clkcfg_i2c_target i_clkcfg_i2c_target (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .scl(sclLine), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .pairEnable(pairEnable), .skewGrpA(skewGrpA),
    .skewGrpB(skewGrpB), .grpSkewBypass(grpSkewBypass),
    .fbSkewBypass(fbSkewBypass), .fbSkew(fbSkew), .inDelay(inDelay),
    .driveGrpA(driveGrpA), .driveGrpB(driveGrpB), .driveFb(driveFb)
  );

  // reference model (R4, R5)
  logic [7:0] expReg [NREG];
  int checks = 0, fails = 0, clkChecks = 0, clkFails = 0;
  int cyc = 0, lastUpd = 0;
  bit done = 0;

  function automatic logic [7:0] modelMask(int i);
    if (i == 5) return 8'h3F;
    if (i == 6 || i == 9 || i == 10) return 8'h38;
    if (i == 7) return 8'hF8;
    if (i == 8) return 8'h7F;
    if (i == 11) return 8'h07;
    return 8'h00;
  endfunction

  function automatic logic [29:0] expVec();
    return {expReg[5][5:0], expReg[6][5:3], expReg[7][5:3], expReg[7][7], expReg[7][6],
            expReg[8][6:4], expReg[8][3:0], expReg[9][5:3], expReg[10][5:3], expReg[11][2:0]};
  endfunction

  wire [29:0] dutVec = {pairEnable, skewGrpA, skewGrpB, grpSkewBypass, fbSkewBypass,
                        fbSkew, inDelay, driveGrpA, driveGrpB, driveFb};

  always @(posedge clk) cyc <= cyc + 1;

  // per-clock comparison of the decoded outputs (R5, R2, R4)
  always @(negedge clk) begin
    if (rstN && !done && cyc > lastUpd + 12) begin
      clkChecks++;
      if (dutVec !== expVec()) begin
        clkFails++;
        $display("FAIL R5 fields at cycle %0d: act=%h exp=%h", cyc, dutVec, expVec());
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    waitN(QTR); mLow = 1'b0; waitN(HALF - QTR); sclLow = 1'b0;
    waitN(HALF); mLow = 1'b1; waitN(HALF); sclLow = 1'b1;
  endtask

  task automatic busStop();
    waitN(QTR); mLow = 1'b1; waitN(HALF - QTR); sclLow = 1'b0;
    waitN(HALF); mLow = 1'b0; waitN(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, input int regIdx, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      waitN(QTR); mLow = ~b[i]; waitN(HALF - QTR); sclLow = 1'b0;
      waitN(HALF); sclLow = 1'b1;
    end
    if (regIdx >= 0 && regIdx < NREG) begin
      expReg[regIdx] = (expReg[regIdx] & ~modelMask(regIdx)) | (b & modelMask(regIdx));
      lastUpd = cyc;
    end
    waitN(QTR); mLow = 1'b0; waitN(HALF - QTR); sclLow = 1'b0;
    waitN(HALF); acked = ~sdaLine; sclLow = 1'b1;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit nack);
    for (int i = 7; i >= 0; i--) begin
      waitN(QTR); mLow = 1'b0; waitN(HALF - QTR); sclLow = 1'b0;
      waitN(HALF); b[i] = sdaLine; sclLow = 1'b1;
    end
    waitN(QTR); mLow = ~nack; waitN(HALF - QTR); sclLow = 1'b0;
    waitN(HALF); sclLow = 1'b1;
  endtask

  task automatic writeTxn(input logic [6:0] a, input int n, input logic [7:0] seed, input bit doStop);
    bit ack;
    busStart();
    sendByte({a, 1'b0}, -1, ack); check(ack, "R1 write address ack", {7'd0, ack}, 8'd1);
    sendByte(8'hC3, -1, ack);     check(ack, "R2 command byte ack", {7'd0, ack}, 8'd1);
    sendByte(8'h00, -1, ack);     check(ack, "R2 count byte ack", {7'd0, ack}, 8'd1);
    for (int k = 0; k < n; k++) begin
      sendByte(seed + 8'(k * 59), k, ack);
      check(ack, (k < NREG) ? "R2 data ack" : "R6 past-end write ack", {7'd0, ack}, 8'd1);
    end
    if (doStop) busStop();
  endtask

  task automatic readTxn(input logic [6:0] a, input int n, input bit extra);
    bit ack;
    logic [7:0] b, e;
    busStart();
    sendByte({a, 1'b1}, -1, ack); check(ack, "R1 read address ack", {7'd0, ack}, 8'd1);
    recvByte(b, 1'b0);            check(b == 8'h09, "R3 count byte", b, 8'h09);
    for (int k = 0; k < n; k++) begin
      recvByte(b, k == n - 1);
      e = (k < NREG) ? expReg[k] : 8'hFF;
      check(b == e, (k < NREG) ? "R3 R4 register read" : "R6 past-end read", b, e);
    end
    if (extra) begin
      recvByte(b, 1'b1);
      check(b == 8'hFF, "R7 bus released after NACK", b, 8'hFF);
    end
    busStop();
  endtask

  task automatic summary();
    int tot, bad;
    done = 1;
    tot = checks + clkChecks;
    bad = fails + clkFails;
    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
  end

  initial begin
    bit ack;
    sclLow = 1'b0;
    expReg[0] = 8'hFF; expReg[1] = 8'hFF; expReg[2] = 8'hFF; expReg[3] = 8'hFF;
    expReg[4] = 8'hFF; expReg[5] = 8'h3F; expReg[6] = 8'h18; expReg[7] = 8'hD8;
    expReg[8] = 8'hB0; expReg[9] = 8'hD8; expReg[10] = 8'hD8; expReg[11] = 8'hFB;
    waitN(5); rstN = 1'b1; waitN(5);
    check(dutVec == expVec(), "R5 reset fields", dutVec[7:0], expVec()[7:0]);
    check(sdaOe == 1'b0, "R9 SDA released after reset", {7'd0, sdaOe}, 8'd0);

    // reset values, count byte, bytes past the end
    readTxn(7'h6A, NREG + 2, 1'b0);
    // full write with header discard, reserved masks, past-end bytes
    writeTxn(7'h6A, NREG + 2, 8'h15, 1'b1);
    readTxn(7'h6A, NREG + 1, 1'b0);

    // R1: address with LSB 1 while addrSel=0 is ignored
    busStart();
    sendByte({7'h6B, 1'b0}, -1, ack); check(!ack, "R1 foreign address no ack", {7'd0, ack}, 8'd0);
    sendByte(8'h00, -1, ack);         check(!ack, "R1 ignored byte no ack", {7'd0, ack}, 8'd0);
    sendByte(8'h00, -1, ack);
    busStop();

    // R1: select input moves the address
    addrSel = 1'b1;
    waitN(4);
    busStart();
    sendByte({7'h6A, 1'b1}, -1, ack); check(!ack, "R1 old address no ack", {7'd0, ack}, 8'd0);
    busStop();
    writeTxn(7'h6B, 6, 8'hA0, 1'b1);
    readTxn(7'h6B, 7, 1'b0);

    // R8: a partial write, a repeated START, then a read from register 0; R7 after NACK
    writeTxn(7'h6B, 9, 8'h4C, 1'b0);
    readTxn(7'h6B, 9, 1'b1);
    // R8: new write after STOP restarts at register 0
    writeTxn(7'h6B, 6, 8'h07, 1'b1);
    readTxn(7'h6B, 6, 1'b0);

    waitN(20);
    summary();
  end

endmodule